// File: doc/BRIEF.md
# PUF Signature Collector and Comparator

This block runs a delay-race PUF core through a fixed series of challenges and gathers the single-bit answers into one signature word. A run begins on `start`. For each step the block puts a challenge index on `chalIdx`. An outside challenge source answers that index with a word on `chalWord`. The block latches the word and passes it to the core on `coreChal` with a one-cycle `coreChalValid`. It then waits for the core's `respValid`, stores the response bit, and moves on to the next index. With the default parameters a run covers 100 challenges of 100 bits each and yields a 100-bit signature.

A finished run does one of two things. If `storeRef` was high at start, the signature becomes the reference. Otherwise it is compared with the reference. The comparison counts the differing bits with a two-stage pipelined adder tree. Each distance result feeds running statistics: the smallest and largest distance, and optionally the sum and the number of comparisons, from which an average can be formed. A `clear` input restarts the statistics.

Top module: `puf_sig_collector`

## Requirements
- R1: After `start` in idle, challenges are requested with index 0 up to SIG_BITS-1 in order. For each one, `coreChal` carries the `chalWord` presented while `chalIdx` showed that index, and `coreChalValid` is high for exactly one cycle. The next index is requested only after a response has been taken.
- R2: The response taken for the challenge with index i is stored in signature bit i, so bit 0 holds the first response. The signature is cleared when a run starts.
- R3: `respValid` outside a pending challenge, and `start` during a run, change neither the signature nor the progress of the run.
- R4: `done` is high for one cycle, in the cycle after the clock edge that captured the last response. `busy` falls at the same edge.
- R5: A run started with `storeRef` high copies its signature into the reference and produces no `distValid`. The reference is zero after reset.
- R6: A run started with `storeRef` low produces a one-cycle `distValid` in the cycle after `done`, with `distance` equal to the number of bits in which the signature and the reference differ.
- R7: In the cycle after `distValid`, `distMin` and `distMax` take the smaller and the larger of their old value and the new distance.
- R8: In the cycle after `distValid`, `distSum` grows by the distance and `distCount` grows by one.
- R9: Reset or `clear` sets `distMin` to all ones and `distMax`, `distSum` and `distCount` to zero. A `clear` in the same cycle as a statistics update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken in idle only) |
| storeRef | input | 1 | With start: the run loads the reference instead of comparing |
| clear | input | 1 | Restart the distance statistics |
| chalIdx | output | IDX_W (7) | Index of the challenge currently requested |
| chalWord | input | CHAL_W (100) | Challenge word from the source for `chalIdx` |
| coreChal | output | CHAL_W (100) | Challenge applied to the PUF core |
| coreChalValid | output | 1 | One-cycle strobe marking a new `coreChal` |
| respBit | input | 1 | Response bit from the core |
| respValid | input | 1 | Response bit is valid |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| signature | output | SIG_BITS (100) | Collected signature |
| distance | output | DIST_W (7) | Last Hamming distance |
| distValid | output | 1 | One-cycle strobe for a new `distance` |
| distMin | output | DIST_W (7) | Smallest distance since clear |
| distMax | output | DIST_W (7) | Largest distance since clear |
| distSum | output | SUM_W (15) | Sum of distances since clear |
| distCount | output | CNT_W (8) | Number of comparisons since clear |

## Verification
Once `start` is seen, the first `coreChalValid` comes two edges later. Each later one comes one edge after the edge that took the previous response. The bench waits for that strobe on falling edges and then holds the response back by a varying number of cycles. Counting from the edge that takes the last response, `done` is due one edge later, `distValid` with its distance two edges later, and the updated statistics three edges later. The bench samples each of these on the falling edge that follows its own rising edge, and checks the previous stage's strobe is low one sample earlier. A clear is driven to meet a pending statistics update on the same edge, so the priority between them is checked.

// File: rtl/puf_sig_pkg.sv
package puf_sig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } runState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic runStart;   // clear signature at start of a run
    logic issue;      // latch challenge word towards the core
    logic capture;    // store response bit at current index
    logic loadRef;    // copy signature into reference
    logic launchCmp;  // start a distance computation
  } ctrlStb_t;

endpackage

// File: rtl/puf_sig_ctrl.sv
module puf_sig_ctrl
  import puf_sig_pkg::*;
#(
  parameter int SIG_BITS = 100,
  localparam int IDX_W = $clog2(SIG_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             storeRef,
  input  logic             respValid,
  output ctrlStb_t         stb,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SIG_BITS - 1);

  runState_t state;
  logic      refMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      refMode <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            idx     <= '0;
            refMode <= storeRef;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (respValid) begin
            if (idx == LAST_IDX) begin
              state <= ST_FIN;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE:  stb.runStart = start;
      ST_ISSUE: stb.issue    = 1'b1;
      ST_WAIT:  stb.capture  = respValid;
      ST_FIN: begin
        stb.loadRef   = refMode;
        stb.launchCmp = !refMode;
      end
      default: stb = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/puf_popcnt_tree.sv
module puf_popcnt_tree #(
  parameter int WIDTH = 100,
  parameter int GROUP = 8,
  localparam int OUT_W = $clog2(WIDTH + 1),
  localparam int NGRP  = (WIDTH + GROUP - 1) / GROUP,
  localparam int GRP_W = $clog2(GROUP + 1),
  localparam int PAD_W = NGRP * GROUP
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic [WIDTH-1:0] vec,
  output logic [OUT_W-1:0] count,
  output logic             countValid
);

  logic [PAD_W-1:0] padded;
  logic [GRP_W-1:0] partComb [NGRP];
  logic [GRP_W-1:0] partQ    [NGRP];
  logic             stage1Valid;
  logic [OUT_W-1:0] totalComb;

  assign padded = PAD_W'(vec);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      partComb[g] = '0;
      for (int b = 0; b < GROUP; b++) begin
        partComb[g] = partComb[g] + GRP_W'(padded[g*GROUP + b]);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       partQ[g] <= '0;
      else if (launch) partQ[g] <= partComb[g];
    end
  end

  always_comb begin
    totalComb = '0;
    for (int g = 0; g < NGRP; g++) begin
      totalComb = totalComb + OUT_W'(partQ[g]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      countValid  <= 1'b0;
      count       <= '0;
    end else begin
      stage1Valid <= launch;
      countValid  <= stage1Valid;
      if (stage1Valid) count <= totalComb;
    end
  end

endmodule

// File: rtl/puf_sig_dpath.sv
module puf_sig_dpath
  import puf_sig_pkg::*;
#(
  parameter int SIG_BITS = 100,
  parameter int CHAL_W   = 100,
  parameter int GROUP    = 8,
  parameter int CNT_W    = 8,
  parameter bit KEEP_SUM = 1'b1,
  localparam int IDX_W  = $clog2(SIG_BITS),
  localparam int DIST_W = $clog2(SIG_BITS + 1),
  localparam int SUM_W  = DIST_W + CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  ctrlStb_t            stb,
  input  logic [IDX_W-1:0]    idx,
  input  logic [CHAL_W-1:0]   chalWord,
  input  logic                respBit,
  output logic [CHAL_W-1:0]   coreChal,
  output logic                coreChalValid,
  output logic [SIG_BITS-1:0] signature,
  output logic [DIST_W-1:0]   distance,
  output logic                distValid,
  output logic [DIST_W-1:0]   distMin,
  output logic [DIST_W-1:0]   distMax,
  output logic [SUM_W-1:0]    distSum,
  output logic [CNT_W-1:0]    distCount
);

  logic [SIG_BITS-1:0] refSig;

  // challenge handoff and signature assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreChal      <= '0;
      coreChalValid <= 1'b0;
      signature     <= '0;
      refSig        <= '0;
    end else begin
      coreChalValid <= stb.issue;
      if (stb.issue)        coreChal       <= chalWord;
      if (stb.runStart)     signature      <= '0;
      else if (stb.capture) signature[idx] <= respBit;
      if (stb.loadRef)      refSig         <= signature;
    end
  end

  puf_popcnt_tree #(
    .WIDTH (SIG_BITS),
    .GROUP (GROUP)
  ) i_tree (
    .clk        (clk),
    .rstN       (rstN),
    .launch     (stb.launchCmp),
    .vec        (signature ^ refSig),
    .count      (distance),
    .countValid (distValid)
  );

  // extreme values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      distMin <= '1;
      distMax <= '0;
    end else if (clear) begin
      distMin <= '1;
      distMax <= '0;
    end else if (distValid) begin
      if (distance < distMin) distMin <= distance;
      if (distance > distMax) distMax <= distance;
    end
  end

  // optional accumulation for an average
  if (KEEP_SUM) begin : g_sum
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        distSum   <= '0;
        distCount <= '0;
      end else if (clear) begin
        distSum   <= '0;
        distCount <= '0;
      end else if (distValid) begin
        distSum   <= distSum + SUM_W'(distance);
        distCount <= distCount + 1'b1;
      end
    end
  end else begin : g_nosum
    assign distSum   = '0;
    assign distCount = '0;
  end

endmodule

// File: rtl/puf_sig_collector.sv
module puf_sig_collector
  import puf_sig_pkg::*;
#(
  parameter int SIG_BITS = 100,
  parameter int CHAL_W   = 100,
  parameter int GROUP    = 8,
  parameter int CNT_W    = 8,
  parameter bit KEEP_SUM = 1'b1,
  localparam int IDX_W  = $clog2(SIG_BITS),
  localparam int DIST_W = $clog2(SIG_BITS + 1),
  localparam int SUM_W  = DIST_W + CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                storeRef,
  input  logic                clear,
  output logic [IDX_W-1:0]    chalIdx,
  input  logic [CHAL_W-1:0]   chalWord,
  output logic [CHAL_W-1:0]   coreChal,
  output logic                coreChalValid,
  input  logic                respBit,
  input  logic                respValid,
  output logic                busy,
  output logic                done,
  output logic [SIG_BITS-1:0] signature,
  output logic [DIST_W-1:0]   distance,
  output logic                distValid,
  output logic [DIST_W-1:0]   distMin,
  output logic [DIST_W-1:0]   distMax,
  output logic [SUM_W-1:0]    distSum,
  output logic [CNT_W-1:0]    distCount
);

  ctrlStb_t stb;

  puf_sig_ctrl #(
    .SIG_BITS (SIG_BITS)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .storeRef  (storeRef),
    .respValid (respValid),
    .stb       (stb),
    .idx       (chalIdx),
    .busy      (busy),
    .done      (done)
  );

  puf_sig_dpath #(
    .SIG_BITS (SIG_BITS),
    .CHAL_W   (CHAL_W),
    .GROUP    (GROUP),
    .CNT_W    (CNT_W),
    .KEEP_SUM (KEEP_SUM)
  ) i_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .clear         (clear),
    .stb           (stb),
    .idx           (chalIdx),
    .chalWord      (chalWord),
    .respBit       (respBit),
    .coreChal      (coreChal),
    .coreChalValid (coreChalValid),
    .signature     (signature),
    .distance      (distance),
    .distValid     (distValid),
    .distMin       (distMin),
    .distMax       (distMax),
    .distSum       (distSum),
    .distCount     (distCount)
  );

endmodule

// File: rtl/puf_sig_chk.sv
module puf_sig_chk #(
  parameter int SIG_BITS = 100,
  parameter int DIST_W   = 7,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                clear,
  input logic                coreChalValid,
  input logic                busy,
  input logic                done,
  input logic [SIG_BITS-1:0] signature,
  input logic [DIST_W-1:0]   distance,
  input logic                distValid,
  input logic [DIST_W-1:0]   distMin,
  input logic [DIST_W-1:0]   distMax,
  input logic [CNT_W-1:0]    distCount
);

  p_chal_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    coreChalValid |=> !coreChalValid);

  p_idle_sig_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(signature));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)) ##1 !done);

  p_dist_follows_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    distValid |-> $past(done));

  p_dist_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    distValid |-> (distance <= DIST_W'(SIG_BITS)));

  p_min_le_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    (distCount != '0) |-> (distMin <= distMax));

  p_clear_init_r9: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (distMin == '1 && distMax == '0 && distCount == '0));

endmodule

bind puf_sig_collector puf_sig_chk #(
  .SIG_BITS (SIG_BITS),
  .DIST_W   (DIST_W),
  .CNT_W    (CNT_W)
) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .start         (start),
  .clear         (clear),
  .coreChalValid (coreChalValid),
  .busy          (busy),
  .done          (done),
  .signature     (signature),
  .distance      (distance),
  .distValid     (distValid),
  .distMin       (distMin),
  .distMax       (distMax),
  .distCount     (distCount)
);

// File: tb/test_puf_sig_collector.sv
module test_puf_sig_collector;

  localparam int N      = 100;
  localparam int CW     = 100;
  localparam int IDX_W  = 7;
  localparam int DIST_W = 7;
  localparam int CNT_W  = 8;
  localparam int SUM_W  = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              storeRef = 1'b0;
  logic              clear = 1'b0;
  logic [IDX_W-1:0]  chalIdx;
  logic [CW-1:0]     chalWord;
  logic [CW-1:0]     coreChal;
  logic              coreChalValid;
  logic              respBit = 1'b0;
  logic              respValid = 1'b0;
  logic              busy;
  logic              done;
  logic [N-1:0]      signature;
  logic [DIST_W-1:0] distance;
  logic              distValid;
  logic [DIST_W-1:0] distMin;
  logic [DIST_W-1:0] distMax;
  logic [SUM_W-1:0]  distSum;
  logic [CNT_W-1:0]  distCount;

  int nChecks = 0;
  int nFails  = 0;

  logic [N-1:0] refModel = '0;
  int eMin = 127, eMax = 0, eSum = 0, eCnt = 0;

  always #4 clk = ~clk;

  function automatic logic [CW-1:0] chalOf(input logic [IDX_W-1:0] i);
    logic [CW-1:0] w;
    w = '0;
    w[IDX_W-1:0]     = i;
    w[CW-1:CW-IDX_W] = ~i;
    w[50]            = i[0] ^ i[3];
    return w;
  endfunction

  assign chalWord = chalOf(chalIdx);

  puf_sig_collector i_puf_sig_collector (
    .clk(clk), .rstN(rstN), .start(start), .storeRef(storeRef), .clear(clear),
    .chalIdx(chalIdx), .chalWord(chalWord), .coreChal(coreChal),
    .coreChalValid(coreChalValid), .respBit(respBit), .respValid(respValid),
    .busy(busy), .done(done), .signature(signature), .distance(distance),
    .distValid(distValid), .distMin(distMin), .distMax(distMax),
    .distSum(distSum), .distCount(distCount)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mkPattern(input logic [31:0] seed);
    logic [N-1:0] p;
    logic [31:0]  s;
    s = seed;
    for (int i = 0; i < N; i++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      p[i] = s[0];
    end
    return p;
  endfunction

  task automatic checkStats(input string req);
    check({req, " min"}, 128'(distMin), 128'(eMin));
    check({req, " max"}, 128'(distMax), 128'(eMax));
    check({req, " sum"}, 128'(distSum), 128'(eSum));
    check({req, " count"}, 128'(distCount), 128'(eCnt));
  endtask

  // one full run; pat is the response sequence the core gives
  task automatic runSig(input logic [N-1:0] pat, input bit isRef,
                        input int lagSeed, input bit poke, input bit clrAtUpd);
    int d;
    @(negedge clk);
    start = 1'b1; storeRef = isRef;
    @(negedge clk);
    start = 1'b0; storeRef = 1'b0;
    for (int i = 0; i < N; i++) begin
      int guard = 0;
      while (!coreChalValid && guard < 20) begin
        @(negedge clk); guard++;
      end
      if (i == 0 || i == N-1 || i == 37) begin
        check("R1 index order", 128'(chalIdx), 128'(i));
        check("R1 challenge word", 128'(coreChal), 128'(chalOf(IDX_W'(i))));
      end
      for (int l = 0; l < (i + lagSeed) % 3; l++) begin
        if (poke && i == 50) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (i == 10 && l == 0) check("R1 no early request", 128'(coreChalValid), 128'(0));
      end
      respBit = pat[i]; respValid = 1'b1;
      @(negedge clk);
      respValid = 1'b0;
    end
    check("R4 done not yet", 128'(done), 128'(0));
    check("R4 busy during finish", 128'(busy), 128'(1));
    @(negedge clk);
    check("R4 done pulse", 128'(done), 128'(1));
    check("R4 busy low", 128'(busy), 128'(0));
    check("R2 signature order", 128'(signature), 128'(pat));
    check("R6 no distance yet", 128'(distValid), 128'(0));
    @(negedge clk);
    check("R4 done one cycle", 128'(done), 128'(0));
    if (isRef) begin
      refModel = pat;
      check("R5 no distance on store", 128'(distValid), 128'(0));
      @(negedge clk);
      checkStats("R5 stats untouched");
    end else begin
      d = $countones(pat ^ refModel);
      check("R6 distValid", 128'(distValid), 128'(1));
      check("R6 distance", 128'(distance), 128'(d));
      if (clrAtUpd) clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      check("R6 distValid pulse", 128'(distValid), 128'(0));
      if (clrAtUpd) begin
        eMin = 127; eMax = 0; eSum = 0; eCnt = 0;
        checkStats("R9 clear beats update");
      end else begin
        if (d < eMin) eMin = d;
        if (d > eMax) eMax = d;
        eSum += d; eCnt++;
        checkStats("R7 R8 update");
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [N-1:0] pa, pb, sigHold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset values
    check("R9 reset busy", 128'(busy), 128'(0));
    check("R9 reset done", 128'(done), 128'(0));
    check("R9 reset distValid", 128'(distValid), 128'(0));
    check("R9 reset signature", 128'(signature), 128'(0));
    checkStats("R9 reset");

    pa = mkPattern(32'hACE1_2468);
    pb = mkPattern(32'h1357_9BDF);

    // compare against the zero reference left by reset (R5)
    runSig(pa, 1'b0, 0, 1'b0, 1'b0);
    runSig(pa, 1'b1, 1, 1'b0, 1'b0);               // R5 store
    runSig(pa, 1'b0, 2, 1'b0, 1'b0);               // distance 0
    runSig(~pa, 1'b0, 0, 1'b0, 1'b0);              // distance 100
    runSig(pa ^ N'(1), 1'b0, 1, 1'b0, 1'b0);       // R2 bit 0
    runSig(pa ^ {1'b1, {(N-1){1'b0}}}, 1'b0, 2, 1'b0, 1'b0); // R2 bit 99
    runSig(pb, 1'b0, 0, 1'b1, 1'b0);               // R3 start while busy

    // R3 stray responses while idle
    sigHold = signature;
    @(negedge clk);
    respValid = 1'b1; respBit = ~signature[0];
    repeat (3) @(negedge clk);
    respValid = 1'b0;
    @(negedge clk);
    check("R3 idle response ignored", 128'(signature), 128'(sigHold));
    check("R3 idle stays idle", 128'(busy), 128'(0));
    check("R3 no challenge issued", 128'(coreChalValid), 128'(0));

    // R9 clear alone
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    eMin = 127; eMax = 0; eSum = 0; eCnt = 0;
    checkStats("R9 clear");

    runSig(pa ^ pb, 1'b0, 1, 1'b0, 1'b0);
    runSig(pb, 1'b0, 2, 1'b0, 1'b1);               // R9 clear on update edge
    runSig(pb, 1'b1, 0, 1'b0, 1'b0);               // new reference
    runSig(pa, 1'b0, 1, 1'b0, 1'b0);
    runSig(pb ^ N'(32'hF0F0_0001), 1'b0, 2, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule